// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder and Decoder

This block sits between a UART's serial bit stream and an infrared transceiver. When the infrared function is active, every 0 bit the UART transmits goes out as one short, active-high light pulse, and every 1 bit goes out as no pulse at all. The pulse width comes from one of two sources. In bit-rate mode it is a fixed fraction of the bit period, counted on the UART's 16x oversampling tick. In low-power mode it is a fixed number of ticks of a separate low-power reference, so it does not change with the bit rate.

On the receive side, the optical input idles high and shows a low level while light is detected. The decoder synchronises this input and finds its falling edge. It then drives a 0 to the UART receiver for one full bit period and returns the line to 1.

While the infrared function is active, the ordinary wired transmit line is held at the marking level and the wired receive input is ignored. While it is inactive, the wired lines pass straight through and the infrared output stays dark. A test loopback sends the inverted infrared output back into the decoder in place of the optical input.

Top module: `sir_codec`

## Requirements
- R1: After a synchronous active-low reset with both enables low, `sir_out` is 0, `txd_out` equals `tx_bit` and `rx_bit` equals `rxd_in`.
- R2: The block is active when `uart_en` and `sir_en` are both high. While active in bit-rate mode (`lp_mode`=0), the bit phase counts `baud16_tick` pulses modulo 16. A 0 on `tx_bit` is latched at phase 0, and `sir_out` is then high from the phase-7 tick to the phase-10 tick: 3 tick periods, which is 12 clocks when there is one tick every 4 clocks.
- R3: In low-power mode (`lp_mode`=1), the pulse for a 0 bit starts at the phase-7 tick. It ends on the third `lp_tick` after it starts, whatever the bit rate. An `lp_tick` in the start cycle is not counted.
- R4: A latched 1 bit produces no pulse in either mode.
- R5: While the block is not active, `sir_out` is 0, `txd_out` equals `tx_bit`, `rx_bit` equals `rxd_in`, and transitions on `sir_in` have no effect.
- R6: While the block is active, `txd_out` is 1 and `rxd_in` has no effect on `rx_bit`.
- R7: While active, a falling edge on `sir_in` (low means light) passes through a 2-stage synchroniser. `rx_bit` goes to 0 on the second clock edge after the input falls. It stays 0 until 16 further `baud16_tick` pulses have occurred, then returns to 1. Low widths are therefore 61 to 64 clocks with one tick every 4 clocks.
- R8: With `loop_test`=1 while active, the decoder input is the inverse of the encoder pulse, so each transmitted 0 bit produces one decoded 0 bit period and `sir_in` is ignored.
- R9: With `uart_en`=0, setting `sir_en`=1 has no effect: the block behaves as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud16_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| lp_tick | input | 1 | One-cycle strobe from the low-power reference |
| uart_en | input | 1 | Overall UART enable |
| sir_en | input | 1 | Infrared function enable |
| lp_mode | input | 1 | 0 = bit-rate pulse width, 1 = low-power pulse width |
| loop_test | input | 1 | Feed the inverted infrared output into the decoder |
| tx_bit | input | 1 | Serial transmit bit from the UART framer (1 = idle) |
| rxd_in | input | 1 | Wired serial receive input |
| sir_in | input | 1 | Optical receive input, low while light is seen |
| txd_out | output | 1 | Wired serial transmit output |
| sir_out | output | 1 | Optical transmit output, high during a pulse |
| rx_bit | output | 1 | Serial bit delivered to the UART receiver |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit, a pulse starting at phase 7 that lasts 3 ticks, a 3-tick low-power width and 2 synchroniser stages. It drives `baud16_tick` every 4 clocks and `lp_tick` every 7 clocks, so the two tick streams are unrelated. This makes the low-power pulse width visibly independent of the bit period, and it lets the phase of the low-power tick vary between pulses. A behavioural model follows the phase, the pulse and the hold time on every clock. Directed windows measure pulse counts and widths for mixed, all-ones, low-power and loopback patterns.

// File: rtl/sir_pkg.sv
// Shared defaults and the pulse-width mode type for the infrared codec.
package sir_pkg;
    localparam int unsigned DEF_TICKS_PER_BIT = 16;
    localparam int unsigned DEF_PULSE_START   = 7;
    localparam int unsigned DEF_PULSE_TICKS   = 3;
    localparam int unsigned DEF_LP_TICKS      = 3;
    localparam int unsigned DEF_SYNC_STAGES   = 2;

    typedef enum logic {
        PW_BITRATE = 1'b0,
        PW_LOWPWR  = 1'b1
    } pw_mode_e;
endpackage

// File: rtl/sir_bit_phase.sv
// Bit phase tracker: counts oversampling ticks within a bit period and
// latches the transmit bit at phase 0.
// Assumes tx_bit is stable for at least one whole bit period.
module sir_bit_phase #(
    parameter int unsigned TICKS_PER_BIT = sir_pkg::DEF_TICKS_PER_BIT,
    localparam int unsigned PW = $clog2(TICKS_PER_BIT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic          tx_bit,
    output logic [PW-1:0] phase,
    output logic          cur_bit
);
    localparam logic [PW-1:0] LAST_PH = PW'(TICKS_PER_BIT - 1);

    // Advance the phase on each tick and sample the bit at phase 0.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase   <= '0;
            cur_bit <= 1'b1;
        end else if (tick) begin
            if (phase == '0) cur_bit <= tx_bit;
            phase <= (phase == LAST_PH) ? '0 : phase + 1'b1;
        end
    end
endmodule

// File: rtl/sir_encoder.sv
// Pulse encoder: turns a latched 0 bit into one active-high pulse that
// starts at a fixed phase. The pulse ends after a fixed number of
// oversampling ticks, or after a fixed number of low-power ticks.
// Assumes PULSE_START + PULSE_TICKS < TICKS_PER_BIT.
module sir_encoder #(
    parameter int unsigned TICKS_PER_BIT = sir_pkg::DEF_TICKS_PER_BIT,
    parameter int unsigned PULSE_START   = sir_pkg::DEF_PULSE_START,
    parameter int unsigned PULSE_TICKS   = sir_pkg::DEF_PULSE_TICKS,
    parameter int unsigned LP_TICKS      = sir_pkg::DEF_LP_TICKS,
    localparam int unsigned PW = $clog2(TICKS_PER_BIT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              baud_tick,
    input  logic              lp_tick,
    input  sir_pkg::pw_mode_e mode,
    input  logic [PW-1:0]     phase,
    input  logic              cur_bit,
    output logic              pulse
);
    localparam int unsigned LW = $clog2(LP_TICKS + 1);
    localparam logic [PW-1:0] START_PH = PW'(PULSE_START);
    localparam logic [PW-1:0] END_PH   = PW'(PULSE_START + PULSE_TICKS);
    localparam logic [LW-1:0] LP_LAST  = LW'(LP_TICKS - 1);

    logic          start;
    logic [LW-1:0] lp_cnt;

    // A pulse starts on the start-phase tick of a 0 bit.
    always_comb start = baud_tick && (phase == START_PH) && !cur_bit;

    // Hold the pulse until the width in the selected mode has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pulse  <= 1'b0;
            lp_cnt <= '0;
        end else if (start) begin
            pulse  <= 1'b1;
            lp_cnt <= '0;
        end else if (pulse) begin
            if (mode == sir_pkg::PW_BITRATE) begin
                if (baud_tick && phase == END_PH) pulse <= 1'b0;
            end else if (lp_tick) begin
                if (lp_cnt == LP_LAST) begin
                    pulse  <= 1'b0;
                    lp_cnt <= '0;
                end else begin
                    lp_cnt <= lp_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sir_decoder.sv
// Pulse decoder: synchronises the active-low optical input, finds its
// falling edge and stretches it into a 0 lasting one bit period.
// Assumes SYNC_STAGES >= 2.
module sir_decoder #(
    parameter int unsigned TICKS_PER_BIT = sir_pkg::DEF_TICKS_PER_BIT,
    parameter int unsigned SYNC_STAGES   = sir_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic baud_tick,
    input  logic line_in,
    output logic bit_out
);
    localparam int unsigned HW = $clog2(TICKS_PER_BIT + 1);
    localparam logic [HW-1:0] HOLD_V = HW'(TICKS_PER_BIT);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [HW-1:0]          hold;
    logic                   fall;

    // Synchroniser chain, idle high.
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n || !run) sync_q[i] <= 1'b1;
            else if (i == 0)     sync_q[i] <= line_in;
            else                 sync_q[i] <= sync_q[(i == 0) ? 0 : i - 1];
        end
    end

    // High-to-low transition at the synchroniser output.
    always_comb fall = sync_q[SYNC_STAGES-1] && !sync_q[SYNC_STAGES-2];

    // Load a full bit period on an edge, count it down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)           hold <= '0;
        else if (fall)                hold <= HOLD_V;
        else if (baud_tick && hold != '0) hold <= hold - 1'b1;
    end

    // Drive 0 while a hold is in progress.
    always_comb bit_out = (hold == '0);
endmodule

// File: rtl/sir_codec.sv
// Infrared SIR codec top: gates the encoder and decoder with the two
// enables, holds the wired transmit line at marking while infrared is
// active, and picks the decoder source for test loopback.
module sir_codec #(
    parameter int unsigned TICKS_PER_BIT = sir_pkg::DEF_TICKS_PER_BIT,
    parameter int unsigned PULSE_START   = sir_pkg::DEF_PULSE_START,
    parameter int unsigned PULSE_TICKS   = sir_pkg::DEF_PULSE_TICKS,
    parameter int unsigned LP_TICKS      = sir_pkg::DEF_LP_TICKS,
    parameter int unsigned SYNC_STAGES   = sir_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud16_tick,
    input  logic lp_tick,
    input  logic uart_en,
    input  logic sir_en,
    input  logic lp_mode,
    input  logic loop_test,
    input  logic tx_bit,
    input  logic rxd_in,
    input  logic sir_in,
    output logic txd_out,
    output logic sir_out,
    output logic rx_bit
);
    localparam int unsigned PW = $clog2(TICKS_PER_BIT);

    logic              active;
    logic [PW-1:0]     phase;
    logic              cur_bit;
    logic              pulse;
    logic              dec_in;
    logic              dec_bit;
    sir_pkg::pw_mode_e mode;

    // Infrared runs only when the UART as a whole is enabled.
    always_comb active = uart_en && sir_en;
    always_comb mode   = lp_mode ? sir_pkg::PW_LOWPWR : sir_pkg::PW_BITRATE;

    sir_bit_phase #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_phase (
        .clk(clk), .rst_n(rst_n), .run(active), .tick(baud16_tick),
        .tx_bit(tx_bit), .phase(phase), .cur_bit(cur_bit)
    );

    sir_encoder #(
        .TICKS_PER_BIT(TICKS_PER_BIT), .PULSE_START(PULSE_START),
        .PULSE_TICKS(PULSE_TICKS), .LP_TICKS(LP_TICKS)
    ) u_enc (
        .clk(clk), .rst_n(rst_n), .run(active), .baud_tick(baud16_tick),
        .lp_tick(lp_tick), .mode(mode), .phase(phase), .cur_bit(cur_bit),
        .pulse(pulse)
    );

    // Loopback feeds the inverted pulse in place of the optical input.
    always_comb dec_in = loop_test ? !pulse : sir_in;

    sir_decoder #(
        .TICKS_PER_BIT(TICKS_PER_BIT), .SYNC_STAGES(SYNC_STAGES)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .run(active), .baud_tick(baud16_tick),
        .line_in(dec_in), .bit_out(dec_bit)
    );

    // Output steering between the wired and the infrared paths.
    always_comb begin
        sir_out = active && pulse;
        txd_out = active ? 1'b1 : tx_bit;
        rx_bit  = active ? dec_bit : rxd_in;
    end
endmodule

// File: rtl/sir_codec_chk.sv
// Property checker for sir_codec, attached by bind.
module sir_codec_chk (
    input logic clk,
    input logic rst_n,
    input logic baud16_tick,
    input logic lp_tick,
    input logic uart_en,
    input logic sir_en,
    input logic lp_mode,
    input logic rxd_in,
    input logic txd_out,
    input logic sir_out,
    input logic rx_bit,
    input logic pulse_q,
    input logic cur_bit
);
    logic on;
    always_comb on = uart_en && sir_en;

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !on |-> !sir_out); // R5
    AST_TXD_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        on |-> txd_out); // R6
    AST_ONE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_q) |-> !$past(cur_bit)); // R4
    AST_NORM_END_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pulse_q) && on && $past(on) && !lp_mode && !$past(lp_mode)) |-> $past(baud16_tick)); // R2
    AST_LP_END_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pulse_q) && on && $past(on) && lp_mode && $past(lp_mode)) |-> $past(lp_tick)); // R3
    AST_HOLD_END_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (on && $past(on) && $rose(rx_bit)) |-> $past(baud16_tick)); // R7
    AST_UART_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !uart_en |-> (!sir_out && rx_bit == rxd_in)); // R9
endmodule

bind sir_codec sir_codec_chk u_chk (
    .clk(clk), .rst_n(rst_n), .baud16_tick(baud16_tick), .lp_tick(lp_tick),
    .uart_en(uart_en), .sir_en(sir_en), .lp_mode(lp_mode), .rxd_in(rxd_in),
    .txd_out(txd_out), .sir_out(sir_out), .rx_bit(rx_bit),
    .pulse_q(pulse), .cur_bit(cur_bit)
);

// File: tb/sir_codec_tb.sv
`timescale 1ns/100ps
module sir_codec_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud16_tick = 1'b0, lp_tick = 1'b0;
    logic uart_en = 1'b0, sir_en = 1'b0, lp_mode = 1'b0, loop_test = 1'b0;
    logic tx_bit = 1'b1, rxd_in = 1'b1, sir_in = 1'b1;
    logic txd_out, sir_out, rx_bit;

    int checks = 0, fails = 0, cyc = 0;

    always #2.5 clk = ~clk;

    sir_codec u_dut (
        .clk(clk), .rst_n(rst_n), .baud16_tick(baud16_tick), .lp_tick(lp_tick),
        .uart_en(uart_en), .sir_en(sir_en), .lp_mode(lp_mode), .loop_test(loop_test),
        .tx_bit(tx_bit), .rxd_in(rxd_in), .sir_in(sir_in),
        .txd_out(txd_out), .sir_out(sir_out), .rx_bit(rx_bit)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Tick sources: oversampling every 4 clocks, low-power every 7.
    int c4 = 0, c7 = 0;
    always @(posedge clk) begin
        #1;
        c4 = (c4 + 1) % 4;
        c7 = (c7 + 1) % 7;
        baud16_tick = (c4 == 3);
        lp_tick     = (c7 == 6);
    end

    // Behavioural reference: phase, latched bit, pulse, sync and hold.
    int ph = 0, bitv = 1, pul = 0, lpc = 0, s1 = 1, s2 = 1, hold = 0;
    always @(posedge clk) begin
        int k, din;
        bit fall, started;
        if (!rst_n || !(uart_en && sir_en)) begin
            ph = 0; bitv = 1; pul = 0; lpc = 0; s1 = 1; s2 = 1; hold = 0;
        end else begin
            din  = loop_test ? (pul == 0) : int'(sir_in);
            fall = (s2 == 1 && s1 == 0);
            s2 = s1; s1 = din;
            if (fall) hold = 16;
            else if (baud16_tick && hold > 0) hold--;
            k = -1; started = 0;
            if (baud16_tick) begin
                k = ph;
                if (k == 0) bitv = int'(tx_bit);
                ph = (ph + 1) % 16;
                if (k == 7 && bitv == 0) begin pul = 1; lpc = 0; started = 1; end
            end
            if (!started && pul == 1) begin
                if (!lp_mode) begin
                    if (k == 10) pul = 0;
                end else if (lp_tick) begin
                    lpc++;
                    if (lpc == 3) begin pul = 0; lpc = 0; end
                end
            end
        end
    end

    // Per-cycle comparison plus pulse and hold width measurement.
    bit meas_clr = 0;
    int sir_rises = 0, sir_wmin = 9999, sir_wmax = 0, sir_cur = 0;
    int rx_falls = 0, rx_wmin = 9999, rx_wmax = 0, rx_cur = 0;
    logic prev_sir = 0, prev_rx = 1;
    always @(negedge clk) begin
        bit act;
        int e_sir, e_txd, e_rx;
        if (meas_clr) begin
            sir_rises = 0; sir_wmin = 9999; sir_wmax = 0;
            rx_falls = 0; rx_wmin = 9999; rx_wmax = 0;
        end
        if (rst_n) begin
            act   = uart_en && sir_en;
            e_sir = (act && pul == 1) ? 1 : 0;
            e_txd = act ? 1 : int'(tx_bit);
            e_rx  = act ? ((hold == 0) ? 1 : 0) : int'(rxd_in);
            chk(int'(sir_out) == e_sir, !act ? "R5 sir_out" : (lp_mode ? "R3 sir_out" : "R2 sir_out"), int'(sir_out), e_sir);
            chk(int'(txd_out) == e_txd, act ? "R6 txd_out" : "R5 txd_out", int'(txd_out), e_txd);
            chk(int'(rx_bit) == e_rx, !act ? "R5 rx_bit" : (loop_test ? "R8 rx_bit" : "R7 rx_bit"), int'(rx_bit), e_rx);
            if (sir_out && !prev_sir) begin sir_rises++; sir_cur = 0; end
            if (sir_out) sir_cur++;
            if (!sir_out && prev_sir) begin
                if (sir_cur < sir_wmin) sir_wmin = sir_cur;
                if (sir_cur > sir_wmax) sir_wmax = sir_cur;
            end
            if (!rx_bit && prev_rx) begin rx_falls++; rx_cur = 0; end
            if (!rx_bit) rx_cur++;
            if (rx_bit && !prev_rx) begin
                if (rx_cur < rx_wmin) rx_wmin = rx_cur;
                if (rx_cur > rx_wmax) rx_wmax = rx_cur;
            end
        end
        prev_sir = sir_out;
        prev_rx  = rx_bit;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_meas();
        step(1); meas_clr = 1; step(1); meas_clr = 0;
    endtask

    // Send n bits, LSB first, each held for one bit period (64 clocks).
    task automatic send(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            tx_bit = b[i];
            step(64);
        end
        tx_bit = 1'b1;
        step(100);
    endtask

    initial begin
        step(5);
        rst_n = 1'b1;
        #1.5;
        chk(sir_out == 1'b0, "R1 sir_out", int'(sir_out), 0);
        chk(txd_out == tx_bit, "R1 txd_out", int'(txd_out), int'(tx_bit));
        chk(rx_bit == rxd_in, "R1 rx_bit", int'(rx_bit), int'(rxd_in));
        step(1);

        // R9: infrared enable without UART enable does nothing.
        sir_en = 1; clear_meas();
        tx_bit = 0; rxd_in = 0;
        for (int i = 0; i < 10; i++) begin sir_in = ~sir_in; step(7); end
        sir_in = 1;
        chk(sir_rises == 0, "R9 pulses", sir_rises, 0);
        chk(rx_falls == 1 && rx_bit == 1'b0, "R9 rx follows rxd_in", int'(rx_bit), 0);
        chk(txd_out == 1'b0, "R9 txd follows tx_bit", int'(txd_out), 0);
        rxd_in = 1; tx_bit = 1; step(2);

        // R2 and R4: bit-rate mode, pattern with four zeros.
        uart_en = 1; clear_meas();
        send(8'hA5, 8);
        chk(sir_rises == 4, "R2 pulse count", sir_rises, 4);
        chk(sir_wmin == 12 && sir_wmax == 12, "R2 pulse width", sir_wmax, 12);
        clear_meas();
        send(8'hFF, 4);
        chk(sir_rises == 0, "R4 ones give no pulse", sir_rises, 0);

        // R6: wired receive ignored while active, txd marked.
        rxd_in = 0; step(3);
        chk(rx_bit == 1'b1, "R6 rxd ignored", int'(rx_bit), 1);
        chk(txd_out == 1'b1, "R6 txd marking", int'(txd_out), 1);
        rxd_in = 1;

        // R3: low-power width set by lp_tick.
        lp_mode = 1; clear_meas();
        send(8'h3C, 8);
        chk(sir_rises == 4, "R3 pulse count", sir_rises, 4);
        chk(sir_wmin >= 15 && sir_wmax <= 21, "R3 pulse width", sir_wmax, 21);
        clear_meas();
        send(8'h0F, 4);
        chk(sir_rises == 0, "R4 ones give no pulse in low-power", sir_rises, 0);
        lp_mode = 0;

        // R7: decoder stretches an input pulse to one bit period.
        clear_meas();
        sir_in = 0; step(5); sir_in = 1; step(100);
        sir_in = 0; step(3); sir_in = 1; step(100);
        chk(rx_falls == 2, "R7 decoded bits", rx_falls, 2);
        chk(rx_wmin >= 61 && rx_wmax <= 64, "R7 hold width", rx_wmax, 64);

        // R8: loopback decodes own pulses, optical input ignored.
        loop_test = 1; clear_meas();
        fork
            send(8'h02, 2);
            for (int i = 0; i < 20; i++) begin sir_in = ~sir_in; step(11); end
        join
        sir_in = 1;
        chk(rx_falls == 1, "R8 loopback decode", rx_falls, 1);
        chk(rx_wmin >= 61 && rx_wmax <= 64, "R8 loopback width", rx_wmax, 64);
        loop_test = 0;

        // R5: disable infrared; output dark, wired paths pass through.
        sir_en = 0; clear_meas();
        tx_bit = 0; rxd_in = 0;
        for (int i = 0; i < 8; i++) begin sir_in = ~sir_in; step(9); end
        chk(sir_rises == 0, "R5 no pulses", sir_rises, 0);
        chk(txd_out == 1'b0, "R5 txd follows", int'(txd_out), 0);
        chk(rx_bit == 1'b0, "R5 rx follows", int'(rx_bit), 0);
        tx_bit = 1; rxd_in = 1; step(4);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule